// File: doc/BRIEF.md
# Lock-free cache maintenance command queue

This block accepts outer-cache maintenance commands from several processors at once, with no software lock. Each processor has its own register lane into a shared setup window. It writes a command word, and for range commands a start address and a byte count. When the command targets specific ways it also writes a way mask. Hardware decides which processor owns the window. Setup writes from any other processor are dropped, and that processor is marked as having lost.

The owner finishes its setup by reading the acceptance register. That read either places the assembled command in a small FIFO or reports that the FIFO is full, and in both cases it frees the window. A processor that reads a nonzero acceptance value repeats its whole setup.

Queued commands run one at a time, in the order they were accepted, on a timed engine that stands in for the cache array. When a command finishes, the engine raises the completion flag of the processor that issued it. Each processor clears its own flag before it issues a new command. It then polls the flag until the flag reads back as exactly 1.

Top module: `maint_cmd_queue`

## Requirements
- R1: After reset no processor owns the window, `engBusy` is 0, and for every processor the acceptance register (word 4) and the completion register (word 5) both read 0.
- R2: While the window is free, a write to the command register (word 0) with bit 0 set grants the window to the writer. When several processors do this in the same cycle, the one with the lowest lane index wins. The owner's base (word 1), length (word 2) and way mask (word 3) writes are the values that reach the engine.
- R3: While another processor owns the window, or is granted it in the same cycle, a processor's writes to words 0 to 3 are discarded. Its next acceptance reads return bit 1 set (value 2). Acceptance reads by a processor that does not own the window never add a command to the queue.
- R4: An acceptance read by the owner always releases the window. If the queue has fewer than QDEPTH entries, the read returns 0 and the command is queued. Otherwise it returns 1 (bit 0), nothing is queued, and later acceptance reads by that processor keep returning 1 until it is next granted the window.
- R5: Queued commands run strictly in acceptance order. `engBusy` stays high for the whole of one command, and the next command starts only after the current one has finished.
- R6: A range command (command bit 4 set) keeps `engBusy` high for BASE_LAT plus ceil(length/2^LINE_SHIFT) cycles. The engine shows its base and length on `engAddr` and `engSize`.
- R7: A whole-cache command (command bit 4 clear) keeps `engBusy` high for FULL_LAT cycles. Any base and length that were written are ignored, and `engAddr` and `engSize` read 0.
- R8: When command bit 5 is set, `engWays` carries the low NWAY bits of the way mask register. When bit 5 is clear, `engWays` is all ones. `engOp` carries command bits 3:1.
- R9: When a command finishes, only the completion register of the processor that issued it becomes 1. A processor writing a value with bit 0 set to its own completion register clears that register to 0.
- R10: A command-register write with bit 0 clear while the window is free grants nothing. It also leaves the writer's acceptance status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | NCPU | Per-lane register write strobe |
| regRd | input | NCPU | Per-lane register read strobe |
| regAddr | input | NCPU*3 | Per-lane register word index |
| regWdata | input | NCPU*32 | Per-lane write data |
| regRdata | output | NCPU*32 | Per-lane read data, valid in the cycle of the read |
| engBusy | output | 1 | Engine is running a command |
| engDone | output | 1 | Last cycle of the running command |
| engCpu | output | clog2(NCPU) | Issuing lane of the running command |
| engOp | output | 3 | Operation code of the running command |
| engRange | output | 1 | Running command acts on a range |
| engAddr | output | 32 | Range start address, 0 for whole-cache |
| engSize | output | 32 | Range length in bytes, 0 for whole-cache |
| engWays | output | NWAY | Ways the running command acts on |

## Verification
On every cycle, the assertions check four things. The queue never overflows or underflows. Window ownership holds steady until the owner's acceptance read and is released by a push. The engine stays busy until its final cycle. A finishing command lands its completion flag on the issuing lane.

Some behaviour only the bench scenarios can show. One is the lowest-index win across every subset of simultaneous requesters. Another is the exact run lengths across a sweep of range sizes. The bench also shows the rejection of a command that arrives at a full queue, first-in-first-out ordering behind a long command, and the dropping of losers' writes.

// File: rtl/maint_cmd_queue_pkg.sv
package maint_cmd_queue_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;
  localparam int DUR_W  = 34;

  // register word indices
  localparam logic [REG_AW-1:0] RG_CMD  = 3'd0;
  localparam logic [REG_AW-1:0] RG_BASE = 3'd1;
  localparam logic [REG_AW-1:0] RG_LEN  = 3'd2;
  localparam logic [REG_AW-1:0] RG_WAYS = 3'd3;
  localparam logic [REG_AW-1:0] RG_ACC  = 3'd4;
  localparam logic [REG_AW-1:0] RG_DONE = 3'd5;

  // command word bits
  localparam int CB_GO     = 0;
  localparam int CB_OP_LO  = 1;
  localparam int CB_RANGE  = 4;
  localparam int CB_WAYSEL = 5;

  // acceptance word bits
  localparam int AB_FULL = 0;
  localparam int AB_LOST = 1;

  typedef struct packed {
    logic              clrSetup;
    logic              ldCmd;
    logic              ldBase;
    logic              ldLen;
    logic              ldWays;
    logic              push;
    logic              pop;
    logic [REG_DW-1:0] wdata;
  } cmqStrobe_t;
endpackage

// File: rtl/maint_cmd_queue_dp.sv
module maint_cmd_queue_dp
  import maint_cmd_queue_pkg::*;
#(
  parameter int NCPU       = 4,
  parameter int QDEPTH     = 4,
  parameter int NWAY       = 8,
  parameter int BASE_LAT   = 4,
  parameter int FULL_LAT   = 20,
  parameter int LINE_SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cmqStrobe_t              strobe,
  input  logic [$clog2(NCPU)-1:0] ownerId,
  output logic                    qFull,
  output logic                    qEmpty,
  output logic [DUR_W-1:0]        headDur,
  output logic [$clog2(NCPU)-1:0] curCpu,
  output logic [2:0]              engOp,
  output logic                    engRange,
  output logic [REG_DW-1:0]       engAddr,
  output logic [REG_DW-1:0]       engSize,
  output logic [NWAY-1:0]         engWays
);
  localparam int CIDW       = $clog2(NCPU);
  localparam int PTRW       = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNTW       = $clog2(QDEPTH + 1);
  localparam int LINE_BYTES = 1 << LINE_SHIFT;

  typedef struct packed {
    logic [2:0]        op;
    logic              rng;
    logic [REG_DW-1:0] base;
    logic [REG_DW-1:0] len;
    logic [NWAY-1:0]   ways;
    logic [CIDW-1:0]   cpu;
  } entry_t;

  // setup shadow registers
  logic [2:0]        shOp;
  logic              shRange;
  logic              shWaySel;
  logic [REG_DW-1:0] shBase;
  logic [REG_DW-1:0] shLen;
  logic [NWAY-1:0]   shWays;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shOp     <= '0;
      shRange  <= 1'b0;
      shWaySel <= 1'b0;
      shBase   <= '0;
      shLen    <= '0;
      shWays   <= '0;
    end else begin
      if (strobe.clrSetup) begin
        shBase <= '0;
        shLen  <= '0;
        shWays <= '0;
      end
      if (strobe.ldCmd) begin
        shOp     <= strobe.wdata[CB_OP_LO +: 3];
        shRange  <= strobe.wdata[CB_RANGE];
        shWaySel <= strobe.wdata[CB_WAYSEL];
      end
      if (strobe.ldBase) shBase <= strobe.wdata;
      if (strobe.ldLen)  shLen  <= strobe.wdata;
      if (strobe.ldWays) shWays <= strobe.wdata[NWAY-1:0];
    end
  end

  entry_t newEntry;
  always_comb begin
    newEntry.op   = shOp;
    newEntry.rng  = shRange;
    newEntry.base = shRange ? shBase : '0;
    newEntry.len  = shRange ? shLen : '0;
    newEntry.ways = shWaySel ? shWays : '1;
    newEntry.cpu  = ownerId;
  end

  // command FIFO
  entry_t          mem [QDEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic [CNTW-1:0] count;

  function automatic logic [PTRW-1:0] nextPtr(input logic [PTRW-1:0] p);
    return (p == PTRW'(QDEPTH - 1)) ? '0 : p + PTRW'(1);
  endfunction

  assign qFull  = (count == CNTW'(QDEPTH));
  assign qEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  // duration of the command at the head
  entry_t      head;
  logic [32:0] lines;
  assign head  = mem[rdPtr];
  assign lines = (33'(head.len) + 33'(LINE_BYTES - 1)) >> LINE_SHIFT;
  assign headDur = head.rng ? (DUR_W'(BASE_LAT) + DUR_W'(lines)) : DUR_W'(FULL_LAT);

  // command held by the engine
  entry_t curQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           curQ <= '0;
    else if (strobe.pop) curQ <= head;
  end

  assign curCpu   = curQ.cpu;
  assign engOp    = curQ.op;
  assign engRange = curQ.rng;
  assign engAddr  = curQ.base;
  assign engSize  = curQ.len;
  assign engWays  = curQ.ways;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !qFull); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !qEmpty); // R5
endmodule

// File: rtl/maint_cmd_queue_ctrl.sv
module maint_cmd_queue_ctrl
  import maint_cmd_queue_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NCPU-1:0]          regWr,
  input  logic [NCPU-1:0]          regRd,
  input  logic [NCPU*REG_AW-1:0]   regAddr,
  input  logic [NCPU*REG_DW-1:0]   regWdata,
  output logic [NCPU*REG_DW-1:0]   regRdata,
  input  logic                     qFull,
  input  logic                     qEmpty,
  input  logic [DUR_W-1:0]         headDur,
  input  logic [$clog2(NCPU)-1:0]  curCpu,
  output cmqStrobe_t               strobe,
  output logic [$clog2(NCPU)-1:0]  ownerId,
  output logic                     engBusy,
  output logic                     engDone
);
  localparam int CIDW = $clog2(NCPU);

  logic [REG_AW-1:0] laneAddr [NCPU];
  logic [REG_DW-1:0] laneData [NCPU];
  logic [NCPU-1:0]   goReq, setupWr, accRd, doneWr, lose;

  for (genvar g = 0; g < NCPU; g++) begin : g_lane
    assign laneAddr[g] = regAddr[g*REG_AW +: REG_AW];
    assign laneData[g] = regWdata[g*REG_DW +: REG_DW];
    assign goReq[g]    = regWr[g] && (laneAddr[g] == RG_CMD) && laneData[g][CB_GO];
    assign setupWr[g]  = regWr[g] && (laneAddr[g] <= RG_WAYS);
    assign accRd[g]    = regRd[g] && !regWr[g] && (laneAddr[g] == RG_ACC);
    assign doneWr[g]   = regWr[g] && (laneAddr[g] == RG_DONE) && laneData[g][0];
  end

  // window ownership
  logic            ownValid;
  logic [CIDW-1:0] ownId;
  logic            winValid, grant, ownerAcc;
  logic [CIDW-1:0] winId;

  always_comb begin
    winId    = '0;
    winValid = 1'b0;
    for (int i = NCPU - 1; i >= 0; i--) begin
      if (goReq[i]) begin
        winId    = CIDW'(i);
        winValid = 1'b1;
      end
    end
  end

  assign grant    = !ownValid && winValid;
  assign ownerAcc = ownValid && accRd[ownId];
  assign ownerId  = ownId;

  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      lose[i] = setupWr[i] && ((ownValid && (ownId != CIDW'(i))) ||
                               (grant && (winId != CIDW'(i))));
    end
  end

  // engine timer
  logic             engBusyQ;
  logic [DUR_W-1:0] remain;

  assign engBusy = engBusyQ;
  assign engDone = engBusyQ && (remain == DUR_W'(1));

  // strobes to the datapath
  always_comb begin
    strobe = '0;
    if (grant) begin
      strobe.clrSetup = 1'b1;
      strobe.ldCmd    = 1'b1;
      strobe.wdata    = laneData[winId];
    end else if (ownValid && regWr[ownId]) begin
      strobe.wdata = laneData[ownId];
      case (laneAddr[ownId])
        RG_CMD:  strobe.ldCmd  = 1'b1;
        RG_BASE: strobe.ldBase = 1'b1;
        RG_LEN:  strobe.ldLen  = 1'b1;
        RG_WAYS: strobe.ldWays = 1'b1;
        default: ;
      endcase
    end
    strobe.push = ownerAcc && !qFull;
    strobe.pop  = !engBusyQ && !qEmpty;
  end

  // per-lane flags
  logic [NCPU-1:0] lostFlag, fullFlag, doneFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownValid <= 1'b0;
      ownId    <= '0;
      lostFlag <= '0;
      fullFlag <= '0;
      doneFlag <= '0;
      engBusyQ <= 1'b0;
      remain   <= '0;
    end else begin
      if (grant) begin
        ownValid <= 1'b1;
        ownId    <= winId;
      end else if (ownerAcc) begin
        ownValid <= 1'b0;
      end

      for (int i = 0; i < NCPU; i++) begin
        if (grant && (winId == CIDW'(i))) begin
          lostFlag[i] <= 1'b0;
          fullFlag[i] <= 1'b0;
        end else if (lose[i]) begin
          lostFlag[i] <= 1'b1;
        end
        if (ownerAcc && (ownId == CIDW'(i))) fullFlag[i] <= qFull;
        if (engDone && (curCpu == CIDW'(i))) doneFlag[i] <= 1'b1;
        else if (doneWr[i])                  doneFlag[i] <= 1'b0;
      end

      if (strobe.pop) begin
        engBusyQ <= 1'b1;
        remain   <= headDur;
      end else if (engDone) begin
        engBusyQ <= 1'b0;
      end else if (engBusyQ) begin
        remain <= remain - DUR_W'(1);
      end
    end
  end

  // read data
  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (regRd[i] && !regWr[i]) begin
        case (laneAddr[i])
          RG_ACC: begin
            if (ownValid && (ownId == CIDW'(i))) begin
              regRdata[i*REG_DW + AB_FULL] = qFull;
            end else begin
              regRdata[i*REG_DW + AB_FULL] = fullFlag[i];
              regRdata[i*REG_DW + AB_LOST] = lostFlag[i];
            end
          end
          RG_DONE: regRdata[i*REG_DW] = doneFlag[i];
          default: ;
        endcase
      end
    end
  end

  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ownValid && !ownerAcc) |=> (ownValid && $stable(ownId))); // R2
  AST_PUSH_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> !ownValid); // R4
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (engBusyQ && !engDone) |=> engBusyQ); // R5
  AST_DONE_TO_ISSUER: assert property (@(posedge clk) disable iff (!rstN)
    engDone |=> doneFlag[$past(curCpu)]); // R9
endmodule

// File: rtl/maint_cmd_queue.sv
module maint_cmd_queue
  import maint_cmd_queue_pkg::*;
#(
  parameter int NCPU       = 4,
  parameter int QDEPTH     = 4,
  parameter int NWAY       = 8,
  parameter int BASE_LAT   = 4,
  parameter int FULL_LAT   = 20,
  parameter int LINE_SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCPU-1:0]         regWr,
  input  logic [NCPU-1:0]         regRd,
  input  logic [NCPU*3-1:0]       regAddr,
  input  logic [NCPU*32-1:0]      regWdata,
  output logic [NCPU*32-1:0]      regRdata,
  output logic                    engBusy,
  output logic                    engDone,
  output logic [$clog2(NCPU)-1:0] engCpu,
  output logic [2:0]              engOp,
  output logic                    engRange,
  output logic [31:0]             engAddr,
  output logic [31:0]             engSize,
  output logic [NWAY-1:0]         engWays
);
  cmqStrobe_t              strobe;
  logic                    qFull, qEmpty;
  logic [DUR_W-1:0]        headDur;
  logic [$clog2(NCPU)-1:0] ownerId;

  maint_cmd_queue_ctrl #(.NCPU(NCPU)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .qFull    (qFull),
    .qEmpty   (qEmpty),
    .headDur  (headDur),
    .curCpu   (engCpu),
    .strobe   (strobe),
    .ownerId  (ownerId),
    .engBusy  (engBusy),
    .engDone  (engDone)
  );

  maint_cmd_queue_dp #(
    .NCPU(NCPU), .QDEPTH(QDEPTH), .NWAY(NWAY),
    .BASE_LAT(BASE_LAT), .FULL_LAT(FULL_LAT), .LINE_SHIFT(LINE_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ownerId  (ownerId),
    .qFull    (qFull),
    .qEmpty   (qEmpty),
    .headDur  (headDur),
    .curCpu   (engCpu),
    .engOp    (engOp),
    .engRange (engRange),
    .engAddr  (engAddr),
    .engSize  (engSize),
    .engWays  (engWays)
  );
endmodule

// File: tb/maint_cmd_queue_tb.sv
module maint_cmd_queue_tb;
  localparam int NCPU = 4;
  localparam int QDEPTH = 4;
  localparam int NWAY = 8;
  localparam int BASE_LAT = 4;
  localparam int FULL_LAT = 20;
  localparam int LINE_SHIFT = 6;
  localparam logic [2:0] A_CMD = 3'd0, A_BASE = 3'd1, A_LEN = 3'd2, A_WAYS = 3'd3,
                         A_ACC = 3'd4, A_DONE = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCPU-1:0] regWr = '0, regRd = '0;
  logic [NCPU*3-1:0] regAddr = '0;
  logic [NCPU*32-1:0] regWdata = '0;
  logic [NCPU*32-1:0] regRdata;
  logic engBusy, engDone, engRange;
  logic [1:0] engCpu;
  logic [2:0] engOp;
  logic [31:0] engAddr, engSize;
  logic [NWAY-1:0] engWays;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  maint_cmd_queue #(.NCPU(NCPU), .QDEPTH(QDEPTH), .NWAY(NWAY), .BASE_LAT(BASE_LAT),
                    .FULL_LAT(FULL_LAT), .LINE_SHIFT(LINE_SHIFT)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engBusy(engBusy), .engDone(engDone),
    .engCpu(engCpu), .engOp(engOp), .engRange(engRange), .engAddr(engAddr),
    .engSize(engSize), .engWays(engWays));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input int op, input bit rng, input bit waySel);
    return {26'b0, waySel, rng, 3'(op), 1'b1};
  endfunction

  task automatic doCycle(input logic [NCPU-1:0] w, input logic [NCPU-1:0] r,
                         input logic [NCPU*3-1:0] a, input logic [NCPU*32-1:0] d,
                         output logic [NCPU*32-1:0] q);
    @(negedge clk);
    regWr = w; regRd = r; regAddr = a; regWdata = d;
    #1 q = regRdata;
    @(posedge clk);
    #1 regWr = '0; regRd = '0;
  endtask

  task automatic wrReg(input int cpu, input logic [2:0] a, input logic [31:0] d);
    logic [NCPU*32-1:0] q;
    logic [NCPU*3-1:0] av = '0;
    logic [NCPU*32-1:0] dv = '0;
    av[cpu*3 +: 3] = a;
    dv[cpu*32 +: 32] = d;
    doCycle(NCPU'(1) << cpu, '0, av, dv, q);
  endtask

  task automatic rdReg(input int cpu, input logic [2:0] a, output logic [31:0] v);
    logic [NCPU*32-1:0] q;
    logic [NCPU*3-1:0] av = '0;
    av[cpu*3 +: 3] = a;
    doCycle('0, NCPU'(1) << cpu, av, '0, q);
    v = q[cpu*32 +: 32];
  endtask

  // waits for a command to run; returns its busy length and fields seen on its first cycle
  task automatic measure(output int dur, output logic [31:0] addr, output logic [31:0] size,
                         output logic [1:0] cpu, output logic [NWAY-1:0] ways);
    int guard = 0;
    dur = 0;
    @(negedge clk);
    while (!engBusy && guard < 1000) begin guard++; @(negedge clk); end
    addr = engAddr; size = engSize; cpu = engCpu; ways = engWays;
    while (engBusy && guard < 100000) begin dur++; guard++; @(negedge clk); end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int dur;
    logic [31:0] ad, sz;
    logic [1:0] cp;
    logic [NWAY-1:0] wy;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    check("R1 engBusy", 32'(engBusy), 0);
    for (int c = 0; c < NCPU; c++) begin
      rdReg(c, A_ACC, v);  check("R1 acceptance", v, 0);
      rdReg(c, A_DONE, v); check("R1 completion", v, 0);
    end

    // R10: command write without go bit grants nothing
    wrReg(1, A_CMD, cmdw(1, 1, 0) & ~32'd1);
    wrReg(2, A_CMD, cmdw(1, 1, 0));
    wrReg(2, A_BASE, 32'h40);
    wrReg(2, A_LEN, 32'd64);
    rdReg(1, A_ACC, v); check("R10 no lost mark", v, 0);
    rdReg(2, A_ACC, v); check("R4 accepted", v, 0);
    measure(dur, ad, sz, cp, wy);
    check("R6 one line", 32'(dur), BASE_LAT + 1);
    check("R2 engine cpu", 32'(cp), 2);
    check("R2 engine addr", ad, 32'h40);
    rdReg(2, A_DONE, v); check("R9 issuer done", v, 1);
    rdReg(1, A_DONE, v); check("R9 other not done", v, 0);
    wrReg(2, A_DONE, 32'd1);
    rdReg(2, A_DONE, v); check("R9 cleared", v, 0);

    // R6 R8: range length sweep
    for (int k = 0; k < 12; k++) begin
      int len = k * 45;
      wrReg(0, A_CMD, cmdw(k % 8, 1, 0));
      wrReg(0, A_BASE, 32'h1000 + 32'(k));
      wrReg(0, A_LEN, 32'(len));
      rdReg(0, A_ACC, v); check("R4 accepted sweep", v, 0);
      measure(dur, ad, sz, cp, wy);
      check("R6 range duration", 32'(dur), 32'(BASE_LAT + (len + 63) / 64));
      check("R6 range size", sz, 32'(len));
      check("R8 all ways", 32'(wy), 32'(8'hFF));
    end

    // R7 R8: whole-cache command with way mask, base and length ignored
    wrReg(3, A_CMD, cmdw(5, 0, 1));
    wrReg(3, A_BASE, 32'h1234);
    wrReg(3, A_LEN, 32'd5000);
    wrReg(3, A_WAYS, 32'h5A);
    rdReg(3, A_ACC, v); check("R4 accepted whole", v, 0);
    measure(dur, ad, sz, cp, wy);
    check("R7 whole duration", 32'(dur), FULL_LAT);
    check("R7 addr zero", ad, 0);
    check("R7 size zero", sz, 0);
    check("R8 way mask", 32'(wy), 32'h5A);
    check("R8 op", 32'(engOp), 5);

    // R2 R3: every subset of simultaneous requesters
    for (int m = 1; m < 16; m++) begin
      int win = 0;
      logic [NCPU*32-1:0] q;
      logic [NCPU*3-1:0] av = '0;
      logic [NCPU*32-1:0] dv = '0;
      for (int c = NCPU - 1; c >= 0; c--) if (m[c]) win = c;
      for (int c = 0; c < NCPU; c++) begin
        av[c*3 +: 3] = A_CMD;
        dv[c*32 +: 32] = cmdw(m % 8, 1, 0);
      end
      doCycle(NCPU'(m), '0, av, dv, q);
      for (int c = 0; c < NCPU; c++) begin
        av[c*3 +: 3] = A_BASE;
        dv[c*32 +: 32] = 32'h100 * 32'(c) + 32'(m << 16);
      end
      doCycle(NCPU'(m), '0, av, dv, q);
      for (int c = 0; c < NCPU; c++) begin
        if (m[c] && c != win) begin
          rdReg(c, A_ACC, v); check("R3 loser flagged", v, 2);
        end
      end
      check("R3 no push by loser", 32'(engBusy), 0);
      rdReg(win, A_ACC, v); check("R2 winner accepted", v, 0);
      measure(dur, ad, sz, cp, wy);
      check("R2 lowest wins", 32'(cp), 32'(win));
      check("R3 winner base kept", ad, 32'h100 * 32'(win) + 32'(m << 16));
      check("R6 zero length", 32'(dur), BASE_LAT);
      rdReg(win, A_DONE, v); check("R9 winner done", v, 1);
      wrReg(win, A_DONE, 32'd1);
    end

    // R4 R5: fill the queue behind a long command, then order
    wrReg(1, A_CMD, cmdw(2, 1, 0));
    wrReg(1, A_LEN, 32'd64 * 60);
    rdReg(1, A_ACC, v); check("R4 long accepted", v, 0);
    for (int k = 1; k <= QDEPTH; k++) begin
      wrReg(k % NCPU, A_CMD, cmdw(3, 1, 0));
      wrReg(k % NCPU, A_BASE, 32'h1000 * 32'(k));
      wrReg(k % NCPU, A_LEN, 32'd64);
      rdReg(k % NCPU, A_ACC, v); check("R4 fill accepted", v, 0);
    end
    wrReg(2, A_CMD, cmdw(4, 1, 0));
    wrReg(2, A_BASE, 32'hDEAD0);
    rdReg(2, A_ACC, v); check("R4 full rejected", v, 1);
    rdReg(2, A_ACC, v); check("R4 full sticky", v, 1);
    measure(dur, ad, sz, cp, wy);
    for (int k = 1; k <= QDEPTH; k++) begin
      measure(dur, ad, sz, cp, wy);
      check("R5 order addr", ad, 32'h1000 * 32'(k));
      check("R5 order cpu", 32'(cp), 32'(k % NCPU));
      check("R6 queued duration", 32'(dur), BASE_LAT + 1);
    end
    repeat (10) @(negedge clk);
    check("R4 rejected never runs", 32'(engBusy), 0);
    wrReg(3, A_CMD, cmdw(1, 0, 0));
    rdReg(3, A_ACC, v); check("R4 window released", v, 0);
    measure(dur, ad, sz, cp, wy);
    check("R7 whole after release", 32'(dur), FULL_LAT);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule